// File: doc/BRIEF.md
# Serial-Loaded Glitch-Free Clock Freeze Controller

This block sits between a clock source and a bank of output clocks. It lets a board controller stop and restart individual outputs for power saving. A two-wire serial port carries the per-output settings: a serial clock that runs all the time, and a data line. The data line rests high. A low sample on it marks the start of a frame, and exactly twelve setting bits follow, one per serial clock period. Each setting bit decides whether one of the twelve gated outputs runs (1) or is held low (0).

The twelve bits are collected in a shadow register. They are copied to the active setting register only when the last bit arrives, so a frame that has not finished never disturbs the outputs. Each gated output carries the active setting into its own clock domain. The gate changes only while that clock is low, so every high pulse that leaves the block has full width.

Two outputs are never gated: the always-on clock and the feedback clock. Whatever is loaded, the loop that depends on them stays intact. The active register can be read back at all times.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: While `arst_n` is low and after it is released, the active register reads all ones, the receiver is idle, and all twelve gated outputs run.
- R2: While idle, a high sample of `ser_dat` on a rising `ser_clk` edge starts nothing. A low sample starts a frame, and the next twelve rising edges capture data bits.
- R3: The first data bit after the start bit lands in `frz_rdbk[0]` and controls `clk_out[0]`. Later bits fill ascending indices up to 11.
- R4: `frz_rdbk` changes only on the `ser_clk` rising edge that captures the twelfth data bit. A frame cut short leaves it unchanged.
- R5: A gated output whose bit is 1 follows its input clock. One whose bit is 0 is held at logic 0.
- R6: `clk_out[12]` (always-on) and `clk_out[13]` (feedback) always equal their input clocks, whatever is loaded.
- R7: Outside reset, each high pulse on a gated output lasts exactly one high phase of its input clock. Freezing or releasing never produces a shortened pulse.
- R8: A low sample on the edge right after the twelfth data bit starts a new frame, so frames may be sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data: idles high, low start bit, then 12 setting bits |
| arst_n | input | 1 | Asynchronous reset, active low |
| clk_in | input | 14 | Input clocks; [11:0] gated, [12] always-on, [13] feedback |
| clk_out | output | 14 | Output clocks, index for index with `clk_in` |
| frz_rdbk | output | 12 | Active setting register (1 = running, 0 = frozen) |

## Verification
The hardest case to reach is a gate that changes while its input clock is high. A runt pulse would appear there if the gate were built wrongly. The input clocks have twelve different half periods that are all unrelated to the serial clock, so each freeze and release lands on a different phase of every output. Every gated high pulse is timed against its input half period across frames that freeze and release alternating, single and full sets of outputs. Back-to-back frames and a frame cut off by reset cover the receiver's edge transitions.

// File: rtl/clkfrz_pkg.sv
package clkfrz_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    localparam int DEF_N_GATED     = 12;
    localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/clkfrz_serial_rx.sv
module clkfrz_serial_rx
    import clkfrz_pkg::*;
#(
    parameter int N_BITS = DEF_N_GATED
) (
    input  logic                      ser_clk,
    input  logic                      arst_n,
    input  logic                      ser_dat,
    output logic [N_BITS-1:0]         active_o,
    output logic                      busy_o,
    output logic [$clog2(N_BITS)-1:0] cnt_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(N_BITS);
    localparam logic [CW-1:0] LAST = CW'(N_BITS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [N_BITS-1:0] shadow;
        logic [N_BITS-1:0] active;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        case (rx_q.st)
            RX_IDLE: begin
                if (!ser_dat) begin
                    rx_d.st  = RX_SHIFT;
                    rx_d.cnt = '0;
                end
            end
            RX_SHIFT: begin
                rx_d.shadow[rx_q.cnt] = ser_dat;
                if (rx_q.cnt == LAST) begin
                    rx_d.active = rx_d.shadow;
                    rx_d.st     = RX_IDLE;
                    rx_d.cnt    = '0;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge ser_clk or negedge arst_n) begin
        if (!arst_n) begin
            rx_q.st     <= RX_IDLE;
            rx_q.cnt    <= '0;
            rx_q.shadow <= '1;
            rx_q.active <= '1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign active_o = rx_q.active;
    assign busy_o   = (rx_q.st == RX_SHIFT);
    assign cnt_o    = rx_q.cnt;
endmodule

// File: rtl/clkfrz_gate_cell.sv
module clkfrz_gate_cell
    import clkfrz_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic arst_n,
    input  logic en_async,
    output logic clk_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   gate_d, gate_q;

    // Bring the enable into this clock's domain on rising edges.
    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], en_async};
        gate_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) sync_q <= '1;
        else         sync_q <= sync_d;
    end

    // The gate moves only on the falling edge, so it cannot change while
    // the clock is high.
    always_ff @(negedge clk_i or negedge arst_n) begin
        if (!arst_n) gate_q <= 1'b1;
        else         gate_q <= gate_d;
    end

    assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/clk_freeze_ctrl.sv
module clk_freeze_ctrl
    import clkfrz_pkg::*;
#(
    parameter int N_GATED     = DEF_N_GATED,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 arst_n,
    input  logic [N_GATED+1:0]   clk_in,
    output logic [N_GATED+1:0]   clk_out,
    output logic [N_GATED-1:0]   frz_rdbk
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW      = $clog2(N_GATED);
    localparam int AON_IDX = N_GATED;
    localparam int FB_IDX  = N_GATED + 1;

    logic          rx_busy;
    logic [CW-1:0] rx_cnt;

    clkfrz_serial_rx #(.N_BITS(N_GATED)) u_rx (
        .ser_clk  (ser_clk),
        .arst_n   (arst_n),
        .ser_dat  (ser_dat),
        .active_o (frz_rdbk),
        .busy_o   (rx_busy),
        .cnt_o    (rx_cnt)
    );

    generate
        for (genvar g = 0; g < N_GATED; g++) begin : g_gate
            clkfrz_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
                .clk_i    (clk_in[g]),
                .arst_n   (arst_n),
                .en_async (frz_rdbk[g]),
                .clk_o    (clk_out[g])
            );
        end
    endgenerate

    // Never gated: always-on and feedback clocks.
    assign clk_out[AON_IDX] = clk_in[AON_IDX];
    assign clk_out[FB_IDX]  = clk_in[FB_IDX];
endmodule

// File: rtl/clk_freeze_ctrl_chk.sv
module clk_freeze_ctrl_chk #(
    parameter int N_GATED = 12
) (
    input logic                       ser_clk,
    input logic                       arst_n,
    input logic                       ser_dat,
    input logic [N_GATED-1:0]         frz_rdbk,
    input logic                       rx_busy,
    input logic [$clog2(N_GATED)-1:0] rx_cnt
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(N_GATED);
    localparam logic [CW-1:0] LAST = CW'(N_GATED - 1);

    AST_IDLE_HIGH_STAYS: assert property (@(posedge ser_clk) disable iff (!arst_n)
        (!rx_busy && ser_dat) |=> !rx_busy); // R2

    AST_START_BIT_ARMS: assert property (@(posedge ser_clk) disable iff (!arst_n)
        (!rx_busy && !ser_dat) |=> (rx_busy && rx_cnt == '0)); // R2

    AST_FRAME_ENDS_AT_LAST: assert property (@(posedge ser_clk) disable iff (!arst_n)
        (rx_busy && rx_cnt == LAST) |=> !rx_busy); // R3

    AST_CNT_IN_RANGE: assert property (@(posedge ser_clk) disable iff (!arst_n)
        rx_busy |-> (rx_cnt <= LAST)); // R3

    AST_RDBK_ONLY_ON_LAST: assert property (@(posedge ser_clk) disable iff (!arst_n)
        !$stable(frz_rdbk) |-> ($past(rx_busy) && $past(rx_cnt) == LAST)); // R4

    AST_BUSY_ADVANCES: assert property (@(posedge ser_clk) disable iff (!arst_n)
        (rx_busy && rx_cnt != LAST) |=> (rx_busy && rx_cnt == $past(rx_cnt) + 1'b1)); // R8
endmodule

bind clk_freeze_ctrl clk_freeze_ctrl_chk #(.N_GATED(N_GATED)) u_chk (.*);

// File: tb/clk_freeze_ctrl_tb_top.sv
module clk_freeze_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NG = 12;
    localparam int NO = NG + 2;

    logic          ser_clk = 1'b0;
    logic          ser_dat = 1'b1;
    logic          arst_n  = 1'b0;
    logic [NO-1:0] clk_in;
    logic [NO-1:0] clk_out;
    logic [NG-1:0] frz_rdbk;

    int n_chk  = 0;
    int n_fail = 0;
    bit pulse_en = 1'b0;

    // 250 MHz serial clock
    always #2 ser_clk = ~ser_clk;

    // Input clocks: gated ones with half period 5+g ns, the others 6 ns.
    generate
        for (genvar g = 0; g < NO; g++) begin : g_src
            localparam int HP = (g < NG) ? (5 + g) : 6;
            logic c = 1'b0;
            initial begin
                #(g);
                forever #(HP) c = ~c;
            end
            assign clk_in[g] = c;
        end
    endgenerate

    clk_freeze_ctrl dut_i (
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .arst_n   (arst_n),
        .clk_in   (clk_in),
        .clk_out  (clk_out),
        .frz_rdbk (frz_rdbk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference of the frame receiver
    logic [NG-1:0] m_reg;
    bit            m_busy;
    bit            m_q[$];

    always @(posedge ser_clk or negedge arst_n) begin
        if (!arst_n) begin
            m_reg  = '1;
            m_busy = 1'b0;
            m_q.delete();
        end else if (!m_busy) begin
            if (!ser_dat) m_busy = 1'b1;
        end else begin
            m_q.push_back(ser_dat);
            if (m_q.size() == NG) begin
                for (int k = 0; k < NG; k++) m_reg[k] = m_q[k];
                m_q.delete();
                m_busy = 1'b0;
            end
        end
    end

    // Per-cycle comparison of the readback (R3, R4)
    always @(negedge ser_clk) begin
        if (arst_n)
            chk(frz_rdbk === m_reg, "R4", "readback vs model", frz_rdbk, m_reg);
    end

    // Pulse-width monitor for gated outputs (R7)
    realtime       t_rise [NG];
    logic [NO-1:0] prev_out;

    always @(clk_out) begin
        for (int k = 0; k < NG; k++) begin
            if (clk_out[k] === 1'b1 && prev_out[k] === 1'b0)
                t_rise[k] = pulse_en ? $realtime : 0.0;
            else if (clk_out[k] === 1'b0 && prev_out[k] === 1'b1 && pulse_en && t_rise[k] > 0.0)
                chk(($realtime - t_rise[k]) == real'(5 + k), "R7", $sformatf("high width out%0d (ps)", k),
                    longint'($rtoi(($realtime - t_rise[k]) * 1000.0)), longint'((5 + k) * 1000));
        end
        prev_out = clk_out;
    end

    task automatic send_bit(input logic b);
        @(negedge ser_clk);
        #1 ser_dat = b;
    endtask

    // Start bit, then bit 0 first
    task automatic send_frame(input logic [NG-1:0] v);
        send_bit(1'b0);
        for (int k = 0; k < NG; k++) send_bit(v[k]);
    endtask

    task automatic idle(input int n);
        repeat (n) send_bit(1'b1);
    endtask

    // Wait for the setting to reach every clock domain, then watch the outputs.
    task automatic check_win(input logic [NG-1:0] exp_en, input string tag);
        logic [NG-1:0] seen;
        bit            pass_bad;
        seen     = '0;
        pass_bad = 1'b0;
        #150.5;
        repeat (80) begin
            #1;
            seen |= clk_out[NG-1:0];
            if (clk_out[NO-1:NG] !== clk_in[NO-1:NG]) pass_bad = 1'b1;
        end
        for (int k = 0; k < NG; k++)
            chk(seen[k] == exp_en[k], "R5", $sformatf("%s out%0d running", tag, k), seen[k], exp_en[k]);
        chk(!pass_bad, "R6", {tag, " ungated outputs follow inputs"}, pass_bad, 0);
    endtask

    initial begin
        #13;
        chk(frz_rdbk === '1, "R1", "readback during reset", frz_rdbk, 12'hFFF);
        @(negedge ser_clk);
        #1 arst_n = 1'b1;
        #20 pulse_en = 1'b1;
        chk(frz_rdbk === '1, "R1", "readback after reset", frz_rdbk, 12'hFFF);
        check_win(12'hFFF, "R1 reset");

        // R2: an idle line starts nothing
        idle(20);
        chk(frz_rdbk === '1, "R2", "idle line keeps register", frz_rdbk, 12'hFFF);

        // R3: bit order, first data bit is index 0
        send_frame(12'h001);
        idle(2);
        chk(frz_rdbk === 12'h001, "R3", "only index 0 enabled", frz_rdbk, 12'h001);
        check_win(12'h001, "R3");

        send_frame(12'hA69);
        idle(2);
        chk(frz_rdbk === 12'hA69, "R5", "mixed pattern", frz_rdbk, 12'hA69);
        check_win(12'hA69, "R5 mixed");

        send_frame(12'h000);
        idle(2);
        check_win(12'h000, "R5 all frozen");

        send_frame(12'hFFF);
        idle(2);
        check_win(12'hFFF, "R7 all released");

        // R8: back-to-back frames
        send_frame(12'h5A3);
        send_frame(12'hC3C);
        idle(2);
        chk(frz_rdbk === 12'hC3C, "R8", "back-to-back second frame", frz_rdbk, 12'hC3C);
        check_win(12'hC3C, "R8");

        // R4: partial frame leaves register, then reset aborts it (R1)
        send_bit(1'b0);
        repeat (6) send_bit(1'b0);
        chk(frz_rdbk === 12'hC3C, "R4", "partial frame no change", frz_rdbk, 12'hC3C);
        pulse_en = 1'b0;
        #1 arst_n = 1'b0;
        #5;
        chk(frz_rdbk === '1, "R1", "reset mid-frame", frz_rdbk, 12'hFFF);
        @(negedge ser_clk);
        #1 arst_n = 1'b1;
        ser_dat = 1'b1;
        idle(4);
        send_frame(12'h0F0);
        idle(2);
        chk(frz_rdbk === 12'h0F0, "R2", "frame after reset aligned", frz_rdbk, 12'h0F0);
        pulse_en = 1'b1;
        check_win(12'h0F0, "R1 post reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule